// File: doc/BRIEF.md
# PS/2 Device Frame Receiver with Keyboard/Mouse Detection

This block takes the two open-collector lines of a PS/2 port (device clock and device data), brings them into the system clock domain and rebuilds the bytes the device sends. Each line passes through a synchroniser and a glitch filter. A falling edge of the filtered device clock samples the filtered data line. The receiver collects a start bit, eight data bits, a parity bit and a stop bit. It then presents the byte with a one-cycle strobe and an error flag that marks a bad parity or stop bit. If the device stalls partway through a frame, a gap timer drops the frame.

The block also works out what sort of device is attached. After a successful power-up self-test, the device reports with the byte 0xAA. A mouse follows that byte at once with its identity byte 0x00, and a keyboard does not. The block waits a bounded time after 0xAA. It reports a mouse if 0x00 arrives, and a keyboard if another byte arrives or the wait runs out.

The host can stop the device from sending by raising an inhibit input. The block then asks the pad logic to hold the device clock line low, and it drops any partly received frame.

Top module: `ps2_rx_classifier`

## Requirements
- R1: A frame is a 0 start bit, eight data bits least significant bit first, a parity bit and a stop bit, each sampled on a falling device-clock edge. After the stop bit, `byte_o` carries the data bits, and `byte_valid_o` is high for exactly one system clock cycle.
- R2: Parity is odd: the eight data bits and the parity bit together must hold an odd number of ones, and the stop bit must be 1. If either check fails, the strobe still occurs and `byte_err_o` is 1; otherwise `byte_err_o` is 0.
- R3: A falling device-clock edge while idle with the data line high is not a start bit. It produces no strobe and does not shift the alignment of the next frame.
- R4: A low pulse on the device clock shorter than FILT_LEN system cycles is filtered out and does not count as an edge.
- R5: If no falling edge arrives for TIMEOUT_CYC system cycles inside a frame, the partial frame is dropped without a strobe, and the next start bit begins a fresh frame.
- R6: While `inhibit_i` is 1, `clk_hold_o` is 1 (hold the device clock low), no strobe is produced, and a partly received frame is dropped. When `inhibit_i` is 0, `clk_hold_o` is 0.
- R7: After reset, `byte_valid_o`, `dev_known_o` and `dev_is_mouse_o` are 0.
- R8: If an error-free 0x00 is the first error-free byte after an error-free 0xAA, and it arrives within ID_WAIT_CYC cycles, `dev_known_o` = 1 and `dev_is_mouse_o` = 1.
- R9: After an error-free 0xAA, an error-free byte other than 0x00, or the expiry of ID_WAIT_CYC cycles with no error-free byte, gives `dev_known_o` = 1 and `dev_is_mouse_o` = 0.
- R10: Bytes flagged with an error do not affect the classification. An error-free 0xAA clears `dev_known_o` and `dev_is_mouse_o` and restarts detection, even after a result is known.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Device clock line as seen at the pad |
| ps2_dat_i | input | 1 | Device data line as seen at the pad |
| inhibit_i | input | 1 | Host request to stop device transmission |
| clk_hold_o | output | 1 | 1 = pad logic pulls the device clock line low |
| byte_o | output | 8 | Last received data byte |
| byte_valid_o | output | 1 | One-cycle strobe for a completed frame |
| byte_err_o | output | 1 | Parity or stop-bit failure for the strobed byte |
| dev_known_o | output | 1 | Device type has been decided |
| dev_is_mouse_o | output | 1 | 1 = mouse, 0 = keyboard (valid when known) |

## Verification
The hardest states to reach are those that need the device to misbehave at a precise point. Examples are a frame abandoned after a few bits, a clock glitch inside a bit period, or a corrupted identity byte arriving inside the detection window. The driver task builds frames bit by bit, so it can stop after any bit, inject a short low pulse in the high half of a bit, or flip the parity or stop bit. A misaligned receiver would then show up as a wrong byte in the scoreboard. Classification windows are shortened by parameter, so the expiry path is reached within the run.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
   typedef enum logic [1:0] {
      CLS_WAIT_TEST,
      CLS_WAIT_ID,
      CLS_DONE
   } cls_state_e;

   localparam logic [7:0] SELF_TEST_OK = 8'hAA;
   localparam logic [7:0] MOUSE_ID     = 8'h00;
   localparam int unsigned DATA_BITS   = 8;
   // bit index of the last frame bit (start = 0 .. stop = 10)
   localparam int unsigned STOP_INDEX  = DATA_BITS + 2;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ps2_line_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_bypass
      assign line_o = synced;
   end else begin : g_filter
      logic [CW-1:0] run_q;
      logic          out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
            out_q <= 1'b1;
         end else if (synced == out_q) begin
            run_q <= '0;
         end else if (run_q == CW'(FILT_LEN - 1)) begin
            out_q <= synced;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
      assign line_o = out_q;

      AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(out_q) |-> ($past(synced) == out_q)); // R4
   end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2_rx_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall_i,
   input  logic       dat_i,
   input  logic       abort_i,
   output logic [7:0] byte_o,
   output logic       valid_o,
   output logic       err_o
);
   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("ps2_frame_rx: TIMEOUT_CYC must be at least 2");
   end

   logic [3:0]    idx_q;
   logic [7:0]    shift_q;
   logic          par_q;
   logic [TW-1:0] tmo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         shift_q <= '0;
         par_q   <= 1'b0;
         tmo_q   <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (abort_i) begin
            idx_q <= '0;
            tmo_q <= '0;
         end else if (fall_i) begin
            tmo_q <= '0;
            if (idx_q == 4'd0) begin
               if (!dat_i) idx_q <= 4'd1;
            end else if (idx_q <= 4'(DATA_BITS)) begin
               shift_q <= {dat_i, shift_q[7:1]};
               idx_q   <= idx_q + 4'd1;
            end else if (idx_q == 4'(DATA_BITS + 1)) begin
               par_q <= dat_i;
               idx_q <= idx_q + 4'd1;
            end else begin
               byte_o  <= shift_q;
               err_o   <= ~(^{shift_q, par_q}) | ~dat_i;
               valid_o <= 1'b1;
               idx_q   <= '0;
            end
         end else if (idx_q != 4'd0) begin
            if (tmo_q == TW'(TIMEOUT_CYC - 1)) begin
               idx_q <= '0;
               tmo_q <= '0;
            end else begin
               tmo_q <= tmo_q + 1'b1;
            end
         end
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R1
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !valid_o); // R6
   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q < TW'(TIMEOUT_CYC)); // R5
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= 4'(STOP_INDEX)); // R1
endmodule

// File: rtl/ps2_dev_classifier.sv
module ps2_dev_classifier
   import ps2_rx_pkg::*;
#(
   parameter int unsigned ID_WAIT_CYC = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] byte_i,
   input  logic       valid_i,
   input  logic       err_i,
   output logic       known_o,
   output logic       mouse_o
);
   localparam int unsigned WW = $clog2(ID_WAIT_CYC + 1);

   if (ID_WAIT_CYC < 2) begin : g_bad_wait
      $error("ps2_dev_classifier: ID_WAIT_CYC must be at least 2");
   end

   cls_state_e    st_q;
   logic [WW-1:0] wait_q;
   logic          good;

   assign good = valid_i & ~err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CLS_WAIT_TEST;
         wait_q  <= '0;
         known_o <= 1'b0;
         mouse_o <= 1'b0;
      end else if (good && byte_i == SELF_TEST_OK) begin
         st_q    <= CLS_WAIT_ID;
         wait_q  <= '0;
         known_o <= 1'b0;
         mouse_o <= 1'b0;
      end else if (st_q == CLS_WAIT_ID) begin
         if (good) begin
            known_o <= 1'b1;
            mouse_o <= (byte_i == MOUSE_ID);
            st_q    <= CLS_DONE;
         end else if (wait_q == WW'(ID_WAIT_CYC - 1)) begin
            known_o <= 1'b1;
            mouse_o <= 1'b0;
            st_q    <= CLS_DONE;
         end else begin
            wait_q <= wait_q + 1'b1;
         end
      end
   end

   AST_MOUSE_NEEDS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      mouse_o |-> known_o); // R8
   AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (good && byte_i == SELF_TEST_OK) |=> (!known_o && !mouse_o)); // R10
   AST_WAITING_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CLS_WAIT_ID) |-> !known_o); // R9
endmodule

// File: rtl/ps2_rx_classifier.sv
module ps2_rx_classifier #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned TIMEOUT_CYC = 5000,
   parameter int unsigned ID_WAIT_CYC = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   input  logic       inhibit_i,
   output logic       clk_hold_o,
   output logic [7:0] byte_o,
   output logic       byte_valid_o,
   output logic       byte_err_o,
   output logic       dev_known_o,
   output logic       dev_is_mouse_o
);
   localparam int unsigned NLINES = 2;

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] flt_lines;
   logic              clk_prev_q;
   logic              fall;

   assign raw_lines = {ps2_dat_i, ps2_clk_i};

   for (genvar li = 0; li < NLINES; li++) begin : g_line
      ps2_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) i_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[li]),
         .line_o(flt_lines[li])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev_q <= 1'b1;
      else        clk_prev_q <= flt_lines[0];
   end
   assign fall       = clk_prev_q & ~flt_lines[0];
   assign clk_hold_o = inhibit_i;

   ps2_frame_rx #(
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) i_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .fall_i (fall),
      .dat_i  (flt_lines[1]),
      .abort_i(inhibit_i),
      .byte_o (byte_o),
      .valid_o(byte_valid_o),
      .err_o  (byte_err_o)
   );

   ps2_dev_classifier #(
      .ID_WAIT_CYC(ID_WAIT_CYC)
   ) i_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_i (byte_o),
      .valid_i(byte_valid_o),
      .err_i  (byte_err_o),
      .known_o(dev_known_o),
      .mouse_o(dev_is_mouse_o)
   );

   AST_NO_STROBE_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_i && $past(inhibit_i)) |-> !byte_valid_o); // R6
endmodule

// File: tb/test_ps2_rx_classifier.sv
module test_ps2_rx_classifier;
   localparam int H       = 20;   // system cycles per half device-clock period
   localparam int TMO     = 400;
   localparam int IDW     = 3000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ps2_clk = 1'b1;
   logic ps2_dat = 1'b1;
   logic inhibit = 1'b0;
   logic clk_hold, bvalid, berr, known, mouse;
   logic [7:0] bdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   ps2_rx_classifier #(
      .SYNC_STAGES(2), .FILT_LEN(4), .TIMEOUT_CYC(TMO), .ID_WAIT_CYC(IDW)
   ) i_ps2_rx_classifier (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
      .inhibit_i(inhibit), .clk_hold_o(clk_hold), .byte_o(bdata),
      .byte_valid_o(bvalid), .byte_err_o(berr), .dev_known_o(known),
      .dev_is_mouse_o(mouse)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one device bit; optional short glitch in the high half
   task automatic bit_out(input logic b, input bit glitch);
      ps2_dat = b;
      if (glitch) begin
         cyc(H / 2);
         ps2_clk = 1'b0;
         cyc(2);
         ps2_clk = 1'b1;
         cyc(H - H / 2 - 2);
      end else begin
         cyc(H);
      end
      ps2_clk = 1'b0;
      cyc(H);
      ps2_clk = 1'b1;
   endtask

   task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                       input bit expect_out, input bit glitch, input string tag);
      logic p;
      p = ~(^b) ^ bad_par;
      if (expect_out) begin
         exp_q.push_back({bad_par | bad_stop, b});
         tag_q.push_back(tag);
      end
      bit_out(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) bit_out(b[i], glitch && (i == 3));
      bit_out(p, 1'b0);
      bit_out(~bad_stop, 1'b0);
      ps2_dat = 1'b1;
      cyc(4 * H);
   endtask

   task automatic send_partial(input logic [7:0] b, input int nbits);
      bit_out(1'b0, 1'b0);
      for (int i = 0; i < nbits; i++) bit_out(b[i], 1'b0);
      ps2_dat = 1'b1;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && bvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3/R5/R6 unexpected strobe actual=%0h expected=none", {berr, bdata});
         end else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {berr, bdata}, e);
         end
      end
   end

   initial begin
      cyc(5);
      // R7: reset state
      check("R7 valid", bvalid, 0);
      check("R7 known", known, 0);
      check("R7 mouse", mouse, 0);
      rst_n = 1'b1;
      cyc(10);
      check("R6 hold idle", clk_hold, 0);

      // R1: plain bytes of varied patterns
      send(8'h1C, 0, 0, 1, 0, "R1 byte 1C");
      send(8'hF0, 0, 0, 1, 0, "R1 byte F0");
      send(8'h81, 0, 0, 1, 0, "R1 byte 81");
      send(8'hFF, 0, 0, 1, 0, "R1 byte FF");
      // R2: parity and stop errors
      send(8'h5A, 1, 0, 1, 0, "R2 bad parity");
      send(8'h33, 0, 1, 1, 0, "R2 bad stop");
      send(8'h00, 0, 0, 1, 0, "R2 clean zero");
      check("R10 err bytes no class", known, 0);
      // R3: stray edge with data high
      bit_out(1'b1, 1'b0);
      cyc(2 * H);
      send(8'h6B, 0, 0, 1, 0, "R3 after stray edge");
      // R4: glitch inside a bit
      send(8'hA5, 0, 0, 1, 1, "R4 glitch ignored");
      // R5: abandoned frame then fresh frame
      send_partial(8'hFF, 3);
      cyc(TMO + 200);
      send(8'h12, 0, 0, 1, 0, "R5 after timeout");
      // R6: inhibit
      send_partial(8'hFF, 4);
      inhibit = 1'b1;
      cyc(2);
      check("R6 hold active", clk_hold, 1);
      send(8'h77, 0, 0, 0, 0, "R6");
      inhibit = 1'b0;
      cyc(3);
      check("R6 hold released", clk_hold, 0);
      cyc(50);
      send(8'h29, 0, 0, 1, 0, "R6 after inhibit");

      // R8: mouse detection
      send(8'hAA, 0, 0, 1, 0, "R8 self test");
      check("R8 unknown while waiting", known, 0);
      send(8'h00, 0, 0, 1, 0, "R8 mouse id");
      check("R8 known", known, 1);
      check("R8 mouse", mouse, 1);
      // R10: fresh self test clears result
      send(8'hAA, 0, 0, 1, 0, "R10 self test");
      check("R10 cleared known", known, 0);
      check("R10 cleared mouse", mouse, 0);
      // R9: window expiry -> keyboard
      cyc(IDW + 100);
      check("R9 timeout known", known, 1);
      check("R9 timeout keyboard", mouse, 0);
      // R9: other byte -> keyboard
      send(8'hAA, 0, 0, 1, 0, "R9 self test");
      send(8'h5A, 0, 0, 1, 0, "R9 other byte");
      check("R9 byte known", known, 1);
      check("R9 byte keyboard", mouse, 0);
      // R10: corrupted id ignored, then expiry gives keyboard
      send(8'hAA, 0, 0, 1, 0, "R10 self test 2");
      send(8'h00, 1, 0, 1, 0, "R10 bad id");
      check("R10 bad id ignored", known, 0);
      cyc(IDW);
      check("R10 expiry known", known, 1);
      check("R10 expiry keyboard", mouse, 0);

      cyc(20);
      check("R1 all expected strobes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule